// File: doc/BRIEF.md
# Pulse-Per-Second Referenced Frequency Accumulator

The block measures the frequency of an unknown signal against an external once-per-second reference pulse. The unknown signal is the block's clock and drives a free-running cycle counter. The reference pulse arrives asynchronously and is brought into that clock domain. Each of its rising edges takes a snapshot of the counter. The modulo difference between two consecutive snapshots is the number of signal cycles in that second.

A start pulse latches a programmed number of seconds and clears the running total. The first snapshot after start only sets the starting point. Each later one-second count is added to a wide sum until the programmed number of seconds has been added. The sum then freezes and a valid flag rises, which gives an average with more resolution than a single second. The last one-second count keeps tracking every later reference edge, so it can serve as a live reading.

Top module: `pps_freq_accum`

## Requirements
- R1: After reset, sec_count_o, sum_o and valid_o are all zero.
- R2: sec_count_o equals the number of clk_i rising edges between two consecutive rising edges of pps_i. It updates on the third clk_i rising edge after pps_i rises, and it holds its value between captures.
- R3: Only a 0-to-1 transition of the synchronized pps_i starts a capture. pps_i held high for many cycles produces exactly one capture.
- R4: The first capture after start_i only sets the starting point. sum_o and sec_count_o stay unchanged.
- R5: Each later one-second count is added to sum_o. valid_o rises in the same cycle that the count for the programmed number of seconds is added.
- R6: While valid_o is high, sum_o and valid_o hold, and sec_count_o keeps updating on every capture.
- R7: start_i (sampled high on a clk_i rising edge) clears sum_o and valid_o, discards the starting point and latches nsec_i. Later changes on nsec_i have no effect until the next start_i.
- R8: When start_i and a capture fall on the same clk_i edge, start_i wins. That capture is discarded, and the next capture becomes the starting point.
- R9: Counts are differences modulo 2^CNT_W, so counter wraparound between captures gives the correct count.
- R10: An nsec_i value of 0 behaves as 1.
- R11: Before the first start_i after reset, reference edges change none of the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Signal being measured; clocks the whole block |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pps_i | input | 1 | Asynchronous once-per-second reference pulse |
| start_i | input | 1 | Begins a new accumulation run |
| nsec_i | input | NSEC_W (16) | Number of seconds to sum; latched at start |
| sec_count_o | output | CNT_W (32) | Most recent one-second count |
| sum_o | output | CNT_W+NSEC_W (48) | Accumulated count |
| valid_o | output | 1 | The programmed number of seconds has been summed |

## Verification
A start request and a reference capture can land on the same clock edge. This is provoked by raising start_i exactly two cycles after pps_i rises, which is the edge on which the synchronized rising edge is taken. It is judged by whether the next reference edge is treated as the starting point (sum stays zero) rather than as a first count. Counter wraparound is checked on a second instance with an 8-bit counter, where several wraps fall inside the run and the counts must still equal the pulse spacing.

// File: rtl/pps_accum_pkg.sv
package pps_accum_pkg;
  localparam int unsigned CNT_W_DEF   = 32;
  localparam int unsigned NSEC_W_DEF  = 16;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/pps_edge_sync.sv
module pps_edge_sync #(
  parameter int unsigned STAGES = pps_accum_pkg::SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pps_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= pps_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[i] <= 1'b0;
        else         sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];

  assign rise_o = sync_q[STAGES-1] & ~last_q;

  // R3: a level held high yields one edge only
  a_r3_single_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/free_cycle_counter.sv
module free_cycle_counter #(
  parameter int unsigned W = pps_accum_pkg::CNT_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + W'(1);
endmodule

// File: rtl/interval_capture.sv
module interval_capture #(
  parameter int unsigned W = pps_accum_pkg::CNT_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         cap_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] diff_o,
  output logic         diff_vld_o
);
  logic [W-1:0] prev_q;
  logic         seeded_q;
  logic         take;

  assign take = cap_i & ~clr_i;  // start wins over a coincident capture (R8)

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= '0;
      seeded_q   <= 1'b0;
      diff_o     <= '0;
      diff_vld_o <= 1'b0;
    end else begin
      diff_vld_o <= 1'b0;
      if (clr_i) begin
        seeded_q <= 1'b0;
      end else if (take) begin
        prev_q   <= val_i;
        seeded_q <= 1'b1;
        if (seeded_q) begin
          diff_o     <= val_i - prev_q;  // modulo 2^W (R9)
          diff_vld_o <= 1'b1;
        end
      end
    end
  end

  // R4: the seeding capture produces no count
  a_r4_seed_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !seeded_q) |=> !diff_vld_o);
  // R2: count holds between captures
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take |=> $stable(diff_o));
endmodule

// File: rtl/accum_ctrl.sv
module accum_ctrl #(
  parameter int unsigned CNT_W  = pps_accum_pkg::CNT_W_DEF,
  parameter int unsigned NSEC_W = pps_accum_pkg::NSEC_W_DEF,
  localparam int unsigned SUM_W = CNT_W + NSEC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NSEC_W-1:0] nsec_i,
  input  logic [CNT_W-1:0]  diff_i,
  input  logic              diff_vld_i,
  output logic              active_o,
  output logic [SUM_W-1:0]  sum_o,
  output logic              valid_o
);
  logic [NSEC_W-1:0] target_q;
  logic [NSEC_W-1:0] done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      sum_o    <= '0;
      valid_o  <= 1'b0;
      target_q <= NSEC_W'(1);
      done_q   <= '0;
    end else if (start_i) begin
      active_o <= 1'b1;
      sum_o    <= '0;
      valid_o  <= 1'b0;
      done_q   <= '0;
      target_q <= (nsec_i == '0) ? NSEC_W'(1) : nsec_i;  // R10
    end else if (diff_vld_i && active_o && !valid_o) begin
      sum_o  <= sum_o + {{NSEC_W{1'b0}}, diff_i};
      done_q <= done_q + NSEC_W'(1);
      if (done_q + NSEC_W'(1) == target_q) valid_o <= 1'b1;
    end
  end

  a_r7_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (sum_o == '0 && !valid_o));
  a_r6_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !start_i) |=> (valid_o && $stable(sum_o)));
  a_r5_done_at_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> (done_q == target_q));
  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> (sum_o == '0 && !valid_o));
endmodule

// File: rtl/pps_freq_accum.sv
module pps_freq_accum #(
  parameter int unsigned CNT_W  = pps_accum_pkg::CNT_W_DEF,
  parameter int unsigned NSEC_W = pps_accum_pkg::NSEC_W_DEF,
  localparam int unsigned SUM_W = CNT_W + NSEC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pps_i,
  input  logic              start_i,
  input  logic [NSEC_W-1:0] nsec_i,
  output logic [CNT_W-1:0]  sec_count_o,
  output logic [SUM_W-1:0]  sum_o,
  output logic              valid_o
);
  logic             rise;
  logic             active;
  logic [CNT_W-1:0] cnt;
  logic             diff_vld;

  pps_edge_sync u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .pps_i (pps_i), .rise_o (rise)
  );

  free_cycle_counter #(.W(CNT_W)) u_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni), .cnt_o (cnt)
  );

  interval_capture #(.W(CNT_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (start_i),
    .cap_i      (rise & active),  // R11
    .val_i      (cnt),
    .diff_o     (sec_count_o),
    .diff_vld_o (diff_vld)
  );

  accum_ctrl #(.CNT_W(CNT_W), .NSEC_W(NSEC_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .nsec_i     (nsec_i),
    .diff_i     (sec_count_o),
    .diff_vld_i (diff_vld),
    .active_o   (active),
    .sum_o      (sum_o),
    .valid_o    (valid_o)
  );
endmodule

// File: tb/pps_freq_accum_test.sv
`timescale 1ns/1ps
module pps_freq_accum_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pps = 1'b0;
  logic        start = 1'b0;
  logic [15:0] nsec = '0;
  logic [3:0]  nsec_w = '0;
  logic [31:0] sec_count;
  logic [47:0] sum;
  logic        valid;
  logic [7:0]  sec_count_w;
  logic [11:0] sum_w;
  logic        valid_w;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit ended  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pps_freq_accum uut (
    .clk_i (clk), .rst_ni (rst_ni), .pps_i (pps), .start_i (start),
    .nsec_i (nsec), .sec_count_o (sec_count), .sum_o (sum), .valid_o (valid)
  );

  pps_freq_accum #(.CNT_W(8), .NSEC_W(4)) uut_w (
    .clk_i (clk), .rst_ni (rst_ni), .pps_i (pps), .start_i (start),
    .nsec_i (nsec_w), .sec_count_o (sec_count_w), .sum_o (sum_w), .valid_o (valid_w)
  );

  task automatic chk(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_start(input int n);
    nsec   = 16'(n);
    nsec_w = 4'(n);
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    nsec   = 16'd9;  // must be ignored (R7)
    nsec_w = 4'd9;
    @(negedge clk);
  endtask

  // entered at a negedge; next rise comes p cycles later
  task automatic pps_pulse(input int p, input int h);
    pps = 1'b1;
    repeat (h) @(negedge clk);
    pps = 1'b0;
    repeat (p - h) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 sec_count", sec_count, 0);
    chk("R1 sum", sum, 0);
    chk("R1 valid", valid, 0);
  endtask

  task automatic t_idle();
    pps_pulse(20, 1);
    pps_pulse(20, 1);
    pps_pulse(20, 1);
    chk("R11 sec_count", sec_count, 0);
    chk("R11 sum", sum, 0);
    chk("R11 valid", valid, 0);
  endtask

  task automatic t_basic();
    do_start(3);
    chk("R7 sum cleared", sum, 0);
    pps_pulse(50, 1);
    chk("R4 seed sum", sum, 0);
    chk("R4 seed sec_count", sec_count, 0);
    pps_pulse(60, 1);
    chk("R2 sec 50", sec_count, 50);
    chk("R5 sum 50", sum, 50);
    chk("R5 valid early", valid, 0);
    pps_pulse(70, 1);
    chk("R2 sec 60", sec_count, 60);
    chk("R5 sum 110", sum, 110);
    pps_pulse(40, 1);
    chk("R2 sec 70", sec_count, 70);
    chk("R5 sum 180", sum, 180);
    chk("R5 valid", valid, 1);
    chk("R7 nsec latched", valid, 1);
    pps_pulse(45, 1);
    chk("R6 sec tracks", sec_count, 40);
    chk("R6 sum frozen", sum, 180);
    pps_pulse(30, 1);
    chk("R6 sec tracks 2", sec_count, 45);
    chk("R6 valid held", valid, 1);
  endtask

  task automatic t_long_high();
    do_start(2);
    pps_pulse(20, 18);
    pps_pulse(22, 20);
    pps_pulse(24, 22);
    chk("R3 sec 22", sec_count, 22);
    chk("R3 sum", sum, 42);
    chk("R3 valid", valid, 1);
  endtask

  task automatic t_zero_n();
    do_start(0);
    pps_pulse(15, 1);
    pps_pulse(17, 1);
    chk("R10 sum", sum, 15);
    chk("R10 valid", valid, 1);
    pps_pulse(15, 1);
    chk("R10 sum frozen", sum, 15);
  endtask

  task automatic t_collide();
    do_start(2);
    pps_pulse(30, 1);
    pps = 1'b1;
    repeat (2) @(negedge clk);
    nsec  = 16'd2;
    nsec_w = 4'd2;
    start = 1'b1;       // coincides with the capture edge
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    pps = 1'b0;
    repeat (40) @(negedge clk);
    chk("R8 start sum", sum, 0);
    pps_pulse(35, 1);
    chk("R8 reseed sum", sum, 0);
    chk("R8 reseed valid", valid, 0);
    pps_pulse(25, 1);
    chk("R8 first count", sum, 35);
    pps_pulse(25, 1);
    chk("R8 sum", sum, 60);
    chk("R8 valid", valid, 1);
  endtask

  task automatic t_wrap();
    do_start(4);
    for (int k = 0; k < 5; k++) pps_pulse(100, 1);
    chk("R9 narrow sec", sec_count_w, 100);
    chk("R9 narrow sum", sum_w, 400);
    chk("R9 narrow valid", valid_w, 1);
    chk("R9 wide sum", sum, 400);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_basic();
    t_long_high();
    t_zero_n();
    t_collide();
    t_wrap();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !ended) begin
      ended = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d cycles expected under 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule